// File: doc/BRIEF.md
# Ethernet Receive Error Statistics Counters

This block keeps three saturating event counters for the receive side of an Ethernet MAC. One counts frames that finish with a failed CRC. One counts frames shorter than the minimum legal length of 64 bytes. One counts assertions of the raw receive-error line from the PHY. The error line is counted once per rising edge, not once per cycle and not once per frame.

Frame events reach the block as a single-cycle end-of-frame strobe. The strobe comes with a CRC-error flag and a 16-bit byte count. The PHY error line is sampled as a level on every clock.

Software reads the counters over a simple word-addressed register bus. Each counter stops at all-ones and holds there. A write of any data to a counter's address returns that counter to zero.

Top module: `rx_err_stats`

## Requirements
- R1: After a synchronous active-low reset all three counters read 0.
- R2: The CRC counter, at byte offset 0x0, increments by one in each cycle where the end-of-frame strobe is high and the CRC-error flag is 1.
- R3: The receive-error counter, at byte offset 0x4, increments once per 0-to-1 transition of the PHY error input. A level held high for many cycles counts once, and each new assertion counts again.
- R4: The short-frame counter, at byte offset 0x8, increments once per end-of-frame strobe whose byte length is below 64. A length of 63 counts; a length of 64 does not.
- R5: A frame that has both a CRC error and a length below 64 increments the CRC and short-frame counters in the same cycle.
- R6: A counter at all-ones (0xFFFFFFFF at the default width of 32) stays at all-ones on further events until it is cleared.
- R7: A write to a counter's offset clears that counter to 0 for any write data. The other counters are unchanged.
- R8: When a clearing write and an increment event hit the same counter in the same cycle, the counter reads 0 afterwards.
- R9: Reads return the counter value, zero-extended to 32 bits, only at offsets 0x0, 0x4 and 0x8. Any other offset, including unaligned ones, reads 0. Writes to any other offset change no counter.
- R10: While the end-of-frame strobe is low, the CRC-error flag and the length field have no effect on any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eof_valid | input | 1 | Single-cycle end-of-frame strobe |
| eof_crc_bad | input | 1 | Frame ended with a CRC error (qualified by eof_valid) |
| eof_len | input | LEN_W (16) | Frame byte length (qualified by eof_valid) |
| phy_rx_err | input | 1 | Raw PHY receive-error level |
| bus_addr | input | ADDR_W (8) | Byte address for reads and writes |
| bus_wr_en | input | 1 | Write strobe; a write clears the addressed counter |
| bus_wr_data | input | DATA_W (32) | Write data, its value is ignored |
| bus_rd_data | output | DATA_W (32) | Read data for bus_addr, combinational |

## Verification
The bench builds the block with CNT_W set to 4, so every counter saturates at 15 after a few events. Holding at all-ones and clearing from all-ones can then be swept many times in a short run, where a 32-bit counter would make them unreachable. Frame lengths 0 to 127 are swept with the CRC flag alternating, which covers the boundary at 63 and 64 and the shared-frame case. All 256 addresses of the default 8-bit bus are read and written, which checks the decode, the rejection of unaligned offsets and the rule that stray writes change nothing.

// File: rtl/rxs_pkg.sv
// Shared constants for the receive error statistics block.
// Assumes the counter order below matches the register word order.
package rxs_pkg;
    localparam int NUM_CNT   = 3;
    localparam int IDX_CRC   = 0;   // word 0, byte offset 0x0
    localparam int IDX_RXERR = 1;   // word 1, byte offset 0x4
    localparam int IDX_SHORT = 2;   // word 2, byte offset 0x8
endpackage

// File: rtl/rxs_sat_counter.sv
// Saturating event counter with synchronous clear.
// Behaviour: a clear has priority over an increment, and the count holds
// once it reaches all-ones. Assumes inc and clr are synchronous to clk.
module rxs_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAX_VAL = '1;

    // Update the count: reset, then clear, then a step that stops at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != MAX_VAL)) begin
            count <= count + 1'b1;
        end
    end

    // R6: once at all-ones, the count stays there until a clear arrives
    a_r6_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAX_VAL && !clr) |=> (count == MAX_VAL));

    // R7/R8: any clear, even one that meets an increment, leaves zero
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R2: an accepted event below the top moves the count up by exactly one
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && count != MAX_VAL) |=> (count == $past(count) + 1'b1));

    // R10: with no event and no clear the count does not move
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(count));
endmodule

// File: rtl/rxs_rise_detect.sv
// Rising-edge detector for the PHY receive-error level.
// Keeps a registered copy of the input and flags cycles where the input is
// high and the copy is low. Assumes the input is already synchronous to clk.
module rxs_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic level_q;

    // Remember the previous sample of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    // Flag the first high cycle of an assertion.
    always_comb rise = level_in && !level_q;

    // R3: a rise is never flagged in two consecutive cycles
    a_r3_one_per_assertion: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R3: a level held high flags nothing in the next cycle
    a_r3_held_level_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (level_in && $past(level_in)) |-> !rise);
endmodule

// File: rtl/rxs_frame_classify.sv
// Turns an end-of-frame report into per-counter increment requests.
// Assumes the strobe is high for one cycle per frame; the flag and length
// are ignored while the strobe is low.
module rxs_frame_classify #(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input  logic             eof_valid,
    input  logic             eof_crc_bad,
    input  logic [LEN_W-1:0] eof_len,
    output logic             crc_hit,
    output logic             short_hit
);
    localparam logic [LEN_W-1:0] MIN_LEN_V = LEN_W'(MIN_LEN);

    // Qualify both frame classes with the strobe; they may fire together.
    always_comb begin
        crc_hit   = eof_valid && eof_crc_bad;
        short_hit = eof_valid && (eof_len < MIN_LEN_V);
    end

    // R10: no frame class is reported without the strobe
    always_comb begin
        a_r10_needs_strobe: assert (eof_valid || !(crc_hit || short_hit));
    end
endmodule

// File: rtl/rxs_reg_decode.sv
// Register bus decode for the counter bank.
// Counters sit at consecutive 32-bit words from byte offset 0. Only aligned
// hits are decoded. A write produces a one-cycle clear for the addressed
// counter; reads are combinational and zero-extended.
module rxs_reg_decode #(
    parameter int NUM   = 3,
    parameter int CNT_W = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr_en,
    input  logic [NUM-1:0][CNT_W-1:0] counts,
    output logic [NUM-1:0]            clr_vec,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;
    logic              aligned;
    logic [NUM-1:0]    sel;

    // Split the byte address into word index and alignment.
    always_comb begin
        word_idx = addr[ADDR_W-1:2];
        aligned  = (addr[1:0] == 2'b00);
    end

    // Build one select line per counter word.
    for (genvar g = 0; g < NUM; g++) begin : g_sel
        always_comb sel[g] = aligned && (word_idx == WORD_W'(g));
    end

    // Writes turn the select into a clear for that counter only.
    always_comb clr_vec = wr_en ? sel : '0;

    // Return the selected counter, zero-extended, or zero on a miss.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM; i++) begin
            if (sel[i]) rd_data[CNT_W-1:0] = counts[i];
        end
    end

    // R7: a write never clears more than one counter
    a_r7_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_vec));

    // R9: without a write no clear is issued
    a_r9_no_clear_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (clr_vec == '0));

    // R9: an address that selects no counter reads as zero
    a_r9_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (rd_data == '0));
endmodule

// File: rtl/rx_err_stats.sv
// Receive error statistics counter bank (top level).
// Three saturating counters: CRC-failed frames, PHY error assertions and
// short frames. Each counter is cleared by any bus write to its word.
// Assumes all inputs are synchronous to clk and CNT_W <= DATA_W.
module rx_err_stats #(
    parameter int CNT_W   = 32,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eof_valid,
    input  logic              eof_crc_bad,
    input  logic [LEN_W-1:0]  eof_len,
    input  logic              phy_rx_err,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wr_data,
    output logic [DATA_W-1:0] bus_rd_data
);
    import rxs_pkg::*;

    logic                          crc_hit;
    logic                          short_hit;
    logic                          err_rise;
    logic [NUM_CNT-1:0]            inc_vec;
    logic [NUM_CNT-1:0]            clr_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0] counts;
    logic                          wr_data_unused;

    // The write data carries no meaning: any value clears.
    always_comb wr_data_unused = ^bus_wr_data;

    rxs_frame_classify #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) u_classify (
        .eof_valid   (eof_valid),
        .eof_crc_bad (eof_crc_bad),
        .eof_len     (eof_len),
        .crc_hit     (crc_hit),
        .short_hit   (short_hit)
    );

    rxs_rise_detect u_err_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (phy_rx_err),
        .rise     (err_rise)
    );

    // Route each event source to its counter slot.
    always_comb begin
        inc_vec            = '0;
        inc_vec[IDX_CRC]   = crc_hit;
        inc_vec[IDX_RXERR] = err_rise;
        inc_vec[IDX_SHORT] = short_hit;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        rxs_sat_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[g]),
            .clr   (clr_vec[g]),
            .count (counts[g])
        );
    end

    rxs_reg_decode #(
        .NUM    (NUM_CNT),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr_en   (bus_wr_en),
        .counts  (counts),
        .clr_vec (clr_vec),
        .rd_data (bus_rd_data)
    );

    // R5: a short frame with a bad CRC moves both frame counters together
    a_r5_dual_count: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_hit && short_hit) |-> (inc_vec[IDX_CRC] && inc_vec[IDX_SHORT]));

    // R1: the cycle after reset, every counter is zero
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (counts == '0));
endmodule

// File: tb/rx_err_stats_tb_top.sv
// Self-checking bench. Built with 4-bit counters so that saturation is reached.
module rx_err_stats_tb_top;
    localparam int CW   = 4;
    localparam int MAXV = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eof_valid = 1'b0;
    logic        eof_crc_bad = 1'b0;
    logic [15:0] eof_len = '0;
    logic        phy_rx_err = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic [31:0] bus_rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    int e_crc = 0, e_err = 0, e_short = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    rx_err_stats #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .eof_valid(eof_valid), .eof_crc_bad(eof_crc_bad), .eof_len(eof_len),
        .phy_rx_err(phy_rx_err),
        .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
        .bus_rd_data(bus_rd_data)
    );

    function automatic int sat_inc(int v);
        return (v >= MAXV) ? MAXV : v + 1;
    endfunction

    function automatic int exp_at(int a);
        if (a == 0) return e_crc;
        if (a == 4) return e_err;
        if (a == 8) return e_short;
        return 0;
    endfunction

    task automatic check_addr(int a, string tag);
        @(negedge clk);
        bus_addr = 8'(a);
        #1;
        n_cmp++;
        if (bus_rd_data !== 32'(exp_at(a))) begin
            n_bad++;
            $display("FAIL %s addr=0x%0h actual=%0d expected=%0d", tag, a, bus_rd_data, exp_at(a));
        end
    endtask

    task automatic check_all(string tag);
        check_addr(0, tag);
        check_addr(4, tag);
        check_addr(8, tag);
    endtask

    task automatic frame(bit crc, int len);
        @(negedge clk);
        eof_valid = 1'b1; eof_crc_bad = crc; eof_len = 16'(len);
        @(negedge clk);
        eof_valid = 1'b0;
        if (crc) e_crc = sat_inc(e_crc);
        if (len < 64) e_short = sat_inc(e_short);
    endtask

    task automatic bus_write(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = 8'(a); bus_wr_en = 1'b1; bus_wr_data = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
        if (a == 0) e_crc = 0;
        if (a == 4) e_err = 0;
        if (a == 8) e_short = 0;
    endtask

    task automatic clear_all();
        bus_write(0, 32'h0);
        bus_write(4, 32'hFFFF_FFFF);
        bus_write(8, 32'h1234_5678);
    endtask

    // Drive the error line with one bit per cycle; count rising edges.
    task automatic err_pattern(logic [15:0] pat);
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            if (pat[i] && !phy_rx_err) e_err = sat_inc(e_err);
            phy_rx_err = pat[i];
        end
        @(negedge clk);
        phy_rx_err = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1");

        // R2 R4 R5: sweep lengths 0..127 with the CRC flag alternating
        for (int len = 0; len < 128; len++) begin
            if (len % 10 == 0) clear_all();
            frame(len[0], len);
            check_addr(0, "R2/R5");
            check_addr(8, "R4/R5");
        end

        // R4: boundary lengths 63 and 64 without CRC error
        clear_all();
        frame(1'b0, 63);
        check_addr(8, "R4 len63");
        frame(1'b0, 64);
        check_addr(8, "R4 len64");
        check_addr(0, "R4 no crc");

        // R10: flag and length ignored while the strobe is low
        clear_all();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            eof_crc_bad = 1'b1; eof_len = 16'(k * 10);
        end
        @(negedge clk);
        eof_crc_bad = 1'b0;
        check_all("R10");

        // R3: held level counts once, toggling counts each assertion
        err_pattern(16'b0111_1111_1111_1110);
        check_addr(4, "R3 held");
        err_pattern(16'b1010_1010_0000_0000);
        check_addr(4, "R3 toggle");
        bus_write(4, 32'h0);
        err_pattern(16'b1100_1100_1100_0000);
        check_addr(4, "R3 pairs");

        // R6: drive each counter past saturation, then clear from all-ones
        clear_all();
        for (int k = 0; k < MAXV + 5; k++) begin
            frame(1'b1, 10);
            err_pattern(16'h0100);
        end
        check_all("R6 saturated");
        frame(1'b1, 5);
        check_all("R6 hold");

        // R7: each write clears only its own counter, any data
        bus_write(4, 32'hA5A5_A5A5);
        check_all("R7 clear rxerr");
        bus_write(0, 32'h0000_0001);
        check_all("R7 clear crc");

        // R8: a clear meeting an increment on the same counter wins
        frame(1'b1, 100);
        frame(1'b1, 100);
        @(negedge clk);
        eof_valid = 1'b1; eof_crc_bad = 1'b1; eof_len = 16'd20;
        bus_addr = 8'h0; bus_wr_en = 1'b1; bus_wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        eof_valid = 1'b0; bus_wr_en = 1'b0;
        e_crc = 0; e_short = sat_inc(e_short);
        check_all("R8 crc");
        @(negedge clk);
        phy_rx_err = 1'b1; bus_addr = 8'h4; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; phy_rx_err = 1'b0;
        e_err = 0;
        check_all("R8 rxerr");

        // R9: read every address; then write every non-counter address
        clear_all();
        frame(1'b1, 10);
        frame(1'b1, 10);
        err_pattern(16'h0101);
        for (int a = 0; a < 256; a++) check_addr(a, "R9 read");
        for (int a = 0; a < 256; a++) begin
            if (a != 0 && a != 4 && a != 8) bus_write(a, 32'hFFFF_FFFF);
        end
        check_all("R9 stray writes");

        finish_run();
    end
endmodule